// File: doc/BRIEF.md
# PTP System Time Counter

This block keeps a 64-bit system time for precision time stamping. Each clock cycle is one base tick. A programmable rate word sets the amount added to the time and how many base ticks pass between additions. Software drives the rate word from a frequency servo, so it can trim the clock rate finely without losing the time already counted.

Software reaches the block through a simple 32-bit register port with single-cycle write and read strobes. A signed 64-bit offset is written in two halves. It takes effect in one step when the upper half is written. The time can be loaded in the same split way. For a consistent 64-bit read, software reads the low time word first. That read freezes a copy of the upper word, and the next read of the high word returns that copy. The running time is also driven on a 64-bit output for stamping logic next to the block.

Top module: `ptp_systime`

## Requirements
- R1: The rate word at address 2 holds the increment amount in bits 23:0 and the period in base ticks in bits 31:24. Reading address 2 returns the word last written.
- R2: The time rises by the increment amount once every period clock cycles. The period count restarts on the write edge of the rate word or of the high time word, so the first addition happens on the period-th edge after that write.
- R3: A period field of zero behaves exactly as a period of one.
- R4: Writing the rate word keeps the accumulated time. Additions already made stay in place, and the new amount and period apply only from the next edge on.
- R5: While the increment amount is zero and no register is written, the time does not change.
- R6: A read of address 0 (time low) returns the low 32 bits of the time and stores the upper 32 bits of the same sample. A read of address 1 (time high) returns that stored word, even if the live upper word has since moved on.
- R7: Writing address 3 (offset low) only stores the word and leaves the time unchanged.
- R8: Writing address 4 (offset high) forms a signed 64-bit value, with the written word above the stored offset low word. That value is added to the time on the same edge. Negative offsets move the time backwards.
- R9: Writing address 0 only stages a low word and does not change the time. Writing address 1 loads the time with the written word above the staged low word.
- R10: A synchronous active-high reset clears the time, the rate word, the offset low word, the staged word, the stored high word and the read data. With the rate word cleared, the time stays frozen at zero.
- R11: Read data appears on rdata in the cycle after the read strobe and holds until the next read. Address 3 reads back the offset low word. Address 4 and unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one base tick |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| sys_time | output | 64 | Live system time |

## Verification
The checks on a frozen time and on offset sums assume the increment amount is zero during those cycles. The check on step spacing assumes the period changes only through a rate-word write, which restarts the count. The monotonic-time check assumes bit 63 of the time stays clear, so no 64-bit wrap occurs. The stimulus meets these assumptions: it uses small time values and performs every offset test with the rate word cleared.

// File: rtl/ptp_systime_pkg.sv
package ptp_systime_pkg;
    localparam int REG_W  = 32;
    localparam int TIME_W = 2 * REG_W;
    localparam int INCV_W = 24;
    localparam int INCP_W = REG_W - INCV_W;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_TIME_LO = 3'd0,
        A_TIME_HI = 3'd1,
        A_RATE    = 3'd2,
        A_OFS_LO  = 3'd3,
        A_OFS_HI  = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/ptp_rate_gen.sv
module ptp_rate_gen #(
    parameter int P_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [P_W-1:0] period,
    input  logic           restart,
    output logic           step
);
    typedef struct packed {
        logic [P_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [P_W-1:0] eff;

    always_comb begin
        eff  = (period == '0) ? P_W'(1) : period;
        step = (st_q.cnt >= eff - P_W'(1));
        st_d = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + P_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/ptp_time_acc.sv
module ptp_time_acc #(
    parameter int T_W = 64,
    parameter int V_W = 24
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           step,
    input  logic [V_W-1:0] inc_val,
    input  logic           load,
    input  logic [T_W-1:0] load_val,
    input  logic           adj_en,
    input  logic [T_W-1:0] adj_val,
    output logic [T_W-1:0] time_o
);
    typedef struct packed {
        logic [T_W-1:0] t;
    } st_t;

    st_t st_d, st_q;
    logic [T_W-1:0] add_d;
    logic [T_W-1:0] ofs_d;

    always_comb begin
        add_d = step   ? T_W'(inc_val) : '0;
        ofs_d = adj_en ? adj_val       : '0;
        st_d  = st_q;
        if (load) st_d.t = load_val;
        else      st_d.t = st_q.t + add_d + ofs_d;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign time_o = st_q.t;
endmodule

// File: rtl/ptp_systime.sv
module ptp_systime
    import ptp_systime_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [TIME_W-1:0] sys_time
);
    typedef struct packed {
        logic [REG_W-1:0] rate;
        logic [REG_W-1:0] ofs_lo;
        logic [REG_W-1:0] stage_lo;
        logic [REG_W-1:0] snap_hi;
        logic [REG_W-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;

    logic [REG_W-1:0] inc_word;
    logic [REG_W-1:0] adj_word;
    logic [REG_W-1:0] snap_word;
    logic             step;
    logic             restart;
    logic             wr_rate, wr_tlo, wr_thi, wr_olo, wr_ohi;

    assign inc_word  = st_q.rate;
    assign adj_word  = st_q.ofs_lo;
    assign snap_word = st_q.snap_hi;
    assign rdata     = st_q.rdata;

    always_comb begin
        wr_rate = wr_en && (addr == A_RATE);
        wr_tlo  = wr_en && (addr == A_TIME_LO);
        wr_thi  = wr_en && (addr == A_TIME_HI);
        wr_olo  = wr_en && (addr == A_OFS_LO);
        wr_ohi  = wr_en && (addr == A_OFS_HI);
        restart = wr_rate || wr_thi;

        st_d = st_q;
        if (wr_rate) st_d.rate     = wdata;
        if (wr_tlo)  st_d.stage_lo = wdata;
        if (wr_olo)  st_d.ofs_lo   = wdata;

        if (rd_en) begin
            case (addr)
                A_TIME_LO: begin
                    st_d.rdata   = sys_time[REG_W-1:0];
                    st_d.snap_hi = sys_time[TIME_W-1:REG_W];
                end
                A_TIME_HI: st_d.rdata = st_q.snap_hi;
                A_RATE:    st_d.rdata = st_q.rate;
                A_OFS_LO:  st_d.rdata = st_q.ofs_lo;
                default:   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    ptp_rate_gen #(
        .P_W (INCP_W)
    ) u_rate (
        .clk     (clk),
        .rst     (rst),
        .period  (inc_word[REG_W-1:INCV_W]),
        .restart (restart),
        .step    (step)
    );

    ptp_time_acc #(
        .T_W (TIME_W),
        .V_W (INCV_W)
    ) u_acc (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .inc_val  (inc_word[INCV_W-1:0]),
        .load     (wr_thi),
        .load_val ({wdata, st_q.stage_lo}),
        .adj_en   (wr_ohi),
        .adj_val  ({wdata, st_q.ofs_lo}),
        .time_o   (sys_time)
    );
endmodule

// File: rtl/ptp_systime_chk.sv
module ptp_systime_chk
    import ptp_systime_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wdata,
    input logic [REG_W-1:0]  inc_word,
    input logic [REG_W-1:0]  adj_word,
    input logic [REG_W-1:0]  snap_word,
    input logic              step,
    input logic              restart,
    input logic [TIME_W-1:0] sys_time
);
    // R5
    frozen_time_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && inc_word[INCV_W-1:0] == '0) |=> $stable(sys_time));

    // R2
    step_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !restart && inc_word[REG_W-1:INCV_W] > 8'd1) |=> !step);

    // R6
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && addr == A_TIME_LO) |=> $stable(snap_word));

    // R7
    ofs_lo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_OFS_LO && inc_word[INCV_W-1:0] == '0) |=> $stable(sys_time));

    // R9
    time_lo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_TIME_LO && inc_word[INCV_W-1:0] == '0) |=> $stable(sys_time));

    // R8
    ofs_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_OFS_HI && inc_word[INCV_W-1:0] == '0)
        |=> sys_time == $past(sys_time) + {$past(wdata), $past(adj_word)});

    // R2
    monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !sys_time[TIME_W-1]) |=> sys_time >= $past(sys_time));
endmodule

bind ptp_systime ptp_systime_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .inc_word  (inc_word),
    .adj_word  (adj_word),
    .snap_word (snap_word),
    .step      (step),
    .restart   (restart),
    .sys_time  (sys_time)
);

// File: tb/ptp_systime_test.sv
module ptp_systime_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {period[8], amount[24], idle cycles[16], expected time[64]}
    localparam logic [111:0] VEC [NVEC] = '{
        {8'd1,   24'd1,        16'd10,  64'd10},
        {8'd4,   24'd3,        16'd10,  64'd6},
        {8'd0,   24'd7,        16'd5,   64'd35},
        {8'd16,  24'h000100,   16'd33,  64'h200},
        {8'd255, 24'hFFFFFF,   16'd600, 64'h1FFFFFE},
        {8'd3,   24'd2,        16'd2,   64'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] sys_time;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    ptp_systime uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .sys_time(sys_time)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        idle(3);
        rst = 1'b0;

        // R10: reset state
        rd(3'd0, r); check("R10 time lo after reset", 64'(r), 64'd0);
        rd(3'd1, r); check("R10 time hi after reset", 64'(r), 64'd0);
        rd(3'd2, r); check("R10 rate after reset", 64'(r), 64'd0);

        // R2 R3: vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0]  p = VEC[i][111:104];
            logic [23:0] v = VEC[i][103:80];
            logic [15:0] w = VEC[i][79:64];
            logic [63:0] e = VEC[i][63:0];
            wr(3'd2, {p, v});
            wr(3'd0, 32'd0);
            wr(3'd1, 32'd0);
            idle(int'(w));
            rd(3'd0, r); check($sformatf("R2 R3 vec%0d lo", i), 64'(r), {32'd0, e[31:0]});
            rd(3'd1, r); check($sformatf("R2 vec%0d hi", i), 64'(r), {32'd0, e[63:32]});
            rd(3'd2, r); check($sformatf("R1 vec%0d rate readback", i), 64'(r), {32'd0, p, v});
        end

        // R6: snapshot of the high word across a carry
        wr(3'd2, {8'd1, 24'h10});
        wr(3'd0, 32'hFFFF_FFF0);
        wr(3'd1, 32'd1);
        rd(3'd0, r); check("R9 R6 lo at load", 64'(r), 64'hFFFF_FFF0);
        rd(3'd1, r); check("R6 hi snapshot", 64'(r), 64'd1);
        idle(3);
        rd(3'd0, r); check("R6 lo after carry", 64'(r), 64'h40);
        rd(3'd1, r); check("R6 hi after carry", 64'(r), 64'd2);

        // R4 R5: freeze keeps time, then a new rate continues from it
        wr(3'd2, {8'd1, 24'd5});
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd0);
        idle(4);
        wr(3'd2, {8'd3, 24'd0});
        idle(10);
        rd(3'd0, r); check("R5 R4 frozen value", 64'(r), 64'd25);
        wr(3'd2, {8'd2, 24'd7});
        idle(4);
        rd(3'd0, r); check("R4 no jump on rate change", 64'(r), 64'd39);

        // R7 R8: offsets with frozen time
        wr(3'd2, 32'd0);
        wr(3'd0, 32'h1000);
        wr(3'd1, 32'd0);
        wr(3'd3, 32'hFFFF_FF00);
        idle(2);
        rd(3'd0, r); check("R7 offset low has no effect", 64'(r), 64'h1000);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd0, r); check("R8 negative offset lo", 64'(r), 64'hF00);
        rd(3'd1, r); check("R8 negative offset hi", 64'(r), 64'd0);
        wr(3'd3, 32'd5);
        wr(3'd4, 32'd3);
        rd(3'd0, r); check("R8 positive offset lo", 64'(r), 64'hF05);
        rd(3'd1, r); check("R8 positive offset hi", 64'(r), 64'd3);
        rd(3'd3, r); check("R11 offset low readback", 64'(r), 64'd5);
        rd(3'd4, r); check("R11 offset high reads zero", 64'(r), 64'd0);
        rd(3'd6, r); check("R11 unused address reads zero", 64'(r), 64'd0);

        // R9: staged low word only, then load
        wr(3'd0, 32'h0000_ABCD);
        rd(3'd0, r); check("R9 staged low no effect", 64'(r), 64'hF05);
        wr(3'd1, 32'h77);
        rd(3'd0, r); check("R9 load lo", 64'(r), 64'hABCD);
        rd(3'd1, r); check("R9 load hi", 64'(r), 64'h77);
        idle(2);
        check("R11 rdata holds", 64'(rdata), 64'h77);

        // R10: reset in mid run
        wr(3'd2, {8'd1, 24'd1});
        idle(5);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        check("R10 rdata cleared", 64'(rdata), 64'd0);
        idle(5);
        rd(3'd0, r); check("R10 time cleared and frozen", 64'(r), 64'd0);
        rd(3'd2, r); check("R10 rate cleared", 64'(r), 64'd0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule